// File: doc/BRIEF.md
# Function-Group Operand Steering Stage

This stage sits between the register-read step and a set of execution pipelines. Each transfer brings three register values and one immediate, each with its own valid flag. It also brings a 2-bit function-group code. From these the stage builds the A, B and C operand buses that the chosen pipeline expects. The add/compare pipeline takes its operands in the default slots. The logical and rotate pipelines are two-operand units whose primary source is the third register value, so that value is crossed over into slot A.

Operand B always carries either the second register value or the extended immediate. The stage registers its result behind a valid/ready handshake. When a two-operand group presents both register-1 and register-3 as valid, the stage raises an error strobe in the same cycle. The transfer is still accepted, and a registered conflict flag travels with the data.

Top module: `opsteer_top`

## Requirements
- R1: For group code 2'b00 (add/compare), out_a is the register-1 value when its flag is set, else zero; out_c is the register-3 value when its flag is set, else zero.
- R2: For group codes 2'b01 (logical) and 2'b10 (rotate), out_a is the register-3 value when its flag is set, otherwise the register-1 value when its flag is set, otherwise zero; out_c is zero.
- R3: When imm_ok is low, out_b is the register-2 value if r2_ok is set, else zero, for every legal group.
- R4: When imm_ok is high, out_b is the 16-bit immediate extended to 64 bits, replicating bit 15 when imm_zext is low and filling with zeros when imm_zext is high; the immediate wins over register-2.
- R5: Group code 2'b11 is reserved: out_a, out_b and out_c are all zero and out_illegal is high for that transfer; out_illegal is low for every other code.
- R6: err_now is high in the same cycle that in_valid is high with a two-operand group and both r1_ok and r3_ok set. Such a transfer is still accepted, out_conflict is high with it, and out_a is the bitwise OR of the two values.
- R7: in_ready equals out_ready. The output register loads on a clock edge where in_valid and out_ready are both high, and its outputs (including out_grp, which echoes the group code) appear after that edge. With out_ready high and in_valid low, out_valid falls. With out_ready low, every output holds.
- R8: A synchronous active-high rst clears out_valid at the next clock edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream transfer valid |
| in_ready | output | 1 | Stage can accept a transfer |
| grp | input | 2 | Function-group code |
| r1_val | input | 64 | Register-1 read value |
| r1_ok | input | 1 | Register-1 value present |
| r2_val | input | 64 | Register-2 read value |
| r2_ok | input | 1 | Register-2 value present |
| r3_val | input | 64 | Register-3 read value |
| r3_ok | input | 1 | Register-3 value present |
| imm_val | input | 16 | Immediate field |
| imm_ok | input | 1 | Immediate present |
| imm_zext | input | 1 | Zero-extend the immediate instead of sign-extending |
| err_now | output | 1 | Same-cycle register-1/register-3 conflict strobe |
| out_ready | input | 1 | Downstream pipeline ready |
| out_valid | output | 1 | Output operands valid |
| out_a | output | 64 | Operand A |
| out_b | output | 64 | Operand B |
| out_c | output | 64 | Operand C |
| out_grp | output | 2 | Group code of the held transfer |
| out_conflict | output | 1 | Held transfer had a register-1/register-3 conflict |
| out_illegal | output | 1 | Held transfer used the reserved group code |

## Verification
Two events can land on the same edge. A conflicting two-operand transfer can be accepted while the downstream side is stalling or releasing. A reset can also arrive while a valid transfer and ready are both presented. The random phase makes both flags dense and toggles out_ready often. Directed steps place a conflict exactly on a stall release and assert rst together with in_valid and out_ready. At each edge the bench compares the combinational err_now and every registered output with a reference model kept in the bench, which tracks what the register must hold.

// File: rtl/opsteer_pkg.sv
package opsteer_pkg;

  typedef enum logic [1:0] {
    GRP_ADD   = 2'b00,
    GRP_LOGIC = 2'b01,
    GRP_ROT   = 2'b10,
    GRP_RSVD  = 2'b11
  } grp_e;

  function automatic logic is_two_op(input grp_e g);
    return (g == GRP_LOGIC) || (g == GRP_ROT);
  endfunction

endpackage

// File: rtl/opsteer_bsel.sv
module opsteer_bsel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] r2_val,
  input  logic              r2_ok,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic              imm_ok,
  input  logic              imm_zext,
  output logic [DATA_W-1:0] b_val
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic              fill_bit;
  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    fill_bit = imm_zext ? 1'b0 : imm_val[IMM_W-1];
    imm_ext  = {{PAD_W{fill_bit}}, imm_val};
  end

  // Immediate has priority; no legal form supplies both.
  always_comb begin
    if (imm_ok)     b_val = imm_ext;
    else if (r2_ok) b_val = r2_val;
    else            b_val = '0;
  end

endmodule

// File: rtl/opsteer_route.sv
module opsteer_route
  import opsteer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter bit A_OR   = 1'b1
) (
  input  grp_e              grp,
  input  logic [DATA_W-1:0] r1_val,
  input  logic              r1_ok,
  input  logic [DATA_W-1:0] r3_val,
  input  logic              r3_ok,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] a_out,
  output logic [DATA_W-1:0] b_out,
  output logic [DATA_W-1:0] c_out,
  output logic              conflict,
  output logic              illegal
);
  logic [DATA_W-1:0] r1_g, r3_g, two_a;

  always_comb begin
    r1_g = {DATA_W{r1_ok}} & r1_val;
    r3_g = {DATA_W{r3_ok}} & r3_val;
  end

  generate
    if (A_OR) begin : g_a_or
      always_comb two_a = r3_g | r1_g;
    end else begin : g_a_mux
      always_comb two_a = r3_ok ? r3_val : r1_g;
    end
  endgenerate

  always_comb begin
    a_out    = '0;
    b_out    = '0;
    c_out    = '0;
    conflict = 1'b0;
    illegal  = 1'b0;
    unique case (grp)
      GRP_ADD: begin
        a_out = r1_g;
        b_out = b_in;
        c_out = r3_g;
      end
      GRP_LOGIC, GRP_ROT: begin
        a_out    = two_a;
        b_out    = b_in;
        conflict = r1_ok & r3_ok;
      end
      default: illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/opsteer_outreg.sv
module opsteer_outreg #(
  parameter int DATA_W = 64,
  parameter int GRP_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_ready,
  input  logic [DATA_W-1:0] d_a,
  input  logic [DATA_W-1:0] d_b,
  input  logic [DATA_W-1:0] d_c,
  input  logic [GRP_W-1:0]  d_grp,
  input  logic              d_conflict,
  input  logic              d_illegal,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_a,
  output logic [DATA_W-1:0] q_b,
  output logic [DATA_W-1:0] q_c,
  output logic [GRP_W-1:0]  q_grp,
  output logic              q_conflict,
  output logic              q_illegal
);
  logic load;
  assign load = in_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst)            q_valid <= 1'b0;
    else if (out_ready) q_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      q_a        <= d_a;
      q_b        <= d_b;
      q_c        <= d_c;
      q_grp      <= d_grp;
      q_conflict <= d_conflict;
      q_illegal  <= d_illegal;
    end
  end

  // R8
  reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !q_valid);

  // R7
  stall_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (q_valid && !out_ready) |=> (q_valid && $stable(q_a) && $stable(q_b) && $stable(q_c)
                                 && $stable(q_grp) && $stable(q_conflict)));

endmodule

// File: rtl/opsteer_top.sv
module opsteer_top
  import opsteer_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  parameter bit A_OR   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        grp,
  input  logic [DATA_W-1:0] r1_val,
  input  logic              r1_ok,
  input  logic [DATA_W-1:0] r2_val,
  input  logic              r2_ok,
  input  logic [DATA_W-1:0] r3_val,
  input  logic              r3_ok,
  input  logic [IMM_W-1:0]  imm_val,
  input  logic              imm_ok,
  input  logic              imm_zext,
  output logic              err_now,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic [DATA_W-1:0] out_c,
  output logic [1:0]        out_grp,
  output logic              out_conflict,
  output logic              out_illegal
);
  logic [DATA_W-1:0] b_sel, a_rt, b_rt, c_rt;
  logic              conf_rt, ill_rt;
  grp_e              grp_c;

  assign grp_c    = grp_e'(grp);
  assign in_ready = out_ready;
  assign err_now  = in_valid & conf_rt;

  opsteer_bsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) bsel_i (
    .r2_val(r2_val), .r2_ok(r2_ok), .imm_val(imm_val), .imm_ok(imm_ok),
    .imm_zext(imm_zext), .b_val(b_sel)
  );

  opsteer_route #(.DATA_W(DATA_W), .A_OR(A_OR)) route_i (
    .grp(grp_c), .r1_val(r1_val), .r1_ok(r1_ok), .r3_val(r3_val), .r3_ok(r3_ok),
    .b_in(b_sel), .a_out(a_rt), .b_out(b_rt), .c_out(c_rt),
    .conflict(conf_rt), .illegal(ill_rt)
  );

  opsteer_outreg #(.DATA_W(DATA_W), .GRP_W(2)) outreg_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .d_a(a_rt), .d_b(b_rt), .d_c(c_rt), .d_grp(grp), .d_conflict(conf_rt),
    .d_illegal(ill_rt), .q_valid(out_valid), .q_a(out_a), .q_b(out_b),
    .q_c(out_c), .q_grp(out_grp), .q_conflict(out_conflict), .q_illegal(out_illegal)
  );

  // R5
  rsvd_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && out_ready && grp == 2'b11) |=> (out_valid && out_illegal));

  // R5
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_a == '0 && out_b == '0 && out_c == '0));

  // R6
  conflict_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (err_now && out_ready) |=> (out_valid && out_conflict &&
                                out_a == ($past(r1_val) | $past(r3_val))));

  // R6
  conflict_group_chk: assert property (@(posedge clk) disable iff (rst)
    err_now |-> (r1_ok && r3_ok && (grp == 2'b01 || grp == 2'b10)));

endmodule

// File: tb/opsteer_top_tb.sv
module opsteer_top_tb_top;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid, in_ready, out_ready;
  logic [1:0]    grp;
  logic [DW-1:0] r1_val, r2_val, r3_val;
  logic          r1_ok, r2_ok, r3_ok, imm_ok, imm_zext, err_now;
  logic [15:0]   imm_val;
  logic          out_valid, out_conflict, out_illegal;
  logic [DW-1:0] out_a, out_b, out_c;
  logic [1:0]    out_grp;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic          m_valid, m_conf, m_ill;
  logic [DW-1:0] m_a, m_b, m_c;
  logic [1:0]    m_grp;

  always #4 clk = ~clk;

  opsteer_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .grp(grp),
    .r1_val(r1_val), .r1_ok(r1_ok), .r2_val(r2_val), .r2_ok(r2_ok),
    .r3_val(r3_val), .r3_ok(r3_ok), .imm_val(imm_val), .imm_ok(imm_ok),
    .imm_zext(imm_zext), .err_now(err_now), .out_ready(out_ready),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c),
    .out_grp(out_grp), .out_conflict(out_conflict), .out_illegal(out_illegal)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ref_b();
    if (imm_ok) return imm_zext ? {48'd0, imm_val} : {{48{imm_val[15]}}, imm_val};
    if (r2_ok)  return r2_val;
    return '0;
  endfunction

  function automatic logic ref_conf();
    return (grp == 2'b01 || grp == 2'b10) && r1_ok && r3_ok;
  endfunction

  // One cycle: inputs are already driven (after negedge).
  task automatic cycle();
    logic [DW-1:0] a1, a3;
    #1;
    chk("R6 err_now", {63'd0, err_now}, {63'd0, in_valid & ref_conf()});
    chk("R7 in_ready", {63'd0, in_ready}, {63'd0, out_ready});
    a1 = r1_ok ? r1_val : '0;
    a3 = r3_ok ? r3_val : '0;
    @(posedge clk);
    if (rst) m_valid = 1'b0;
    else if (out_ready) begin
      m_valid = in_valid;
      if (in_valid) begin
        m_grp  = grp;
        m_conf = ref_conf();
        m_ill  = (grp == 2'b11);
        case (grp)
          2'b00: begin m_a = a1; m_b = ref_b(); m_c = a3; end
          2'b11: begin m_a = '0; m_b = '0; m_c = '0; end
          default: begin m_a = a3 | a1; m_b = ref_b(); m_c = '0; end
        endcase
      end
    end
    #1;
    chk(rst ? "R8 valid" : "R7 valid", {63'd0, out_valid}, {63'd0, m_valid});
    if (m_valid) begin
      if (m_ill)       chk("R5 a", out_a, m_a);
      else if (m_conf) chk("R6 a", out_a, m_a);
      else if (m_grp == 2'b00) chk("R1 a", out_a, m_a);
      else             chk("R2 a", out_a, m_a);
      chk(m_ill ? "R5 b" : "R3/R4 b", out_b, m_b);
      chk(m_grp == 2'b00 ? "R1 c" : "R2 c", out_c, m_c);
      chk("R7 grp", {62'd0, out_grp}, {62'd0, m_grp});
      chk("R6 conflict", {63'd0, out_conflict}, {63'd0, m_conf});
      chk("R5 illegal", {63'd0, out_illegal}, {63'd0, m_ill});
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic v, input logic rdy, input logic [1:0] g,
                       input logic o1, input logic o2, input logic o3,
                       input logic oi, input logic zx, input logic [15:0] im);
    in_valid = v; out_ready = rdy; grp = g;
    r1_ok = o1; r2_ok = o2; r3_ok = o3; imm_ok = oi; imm_zext = zx; imm_val = im;
    r1_val = {$urandom, $urandom}; r2_val = {$urandom, $urandom};
    r3_val = {$urandom, $urandom};
  endtask

  initial begin
    void'($urandom(32'd20251));
    m_valid = 0; m_conf = 0; m_ill = 0; m_a = '0; m_b = '0; m_c = '0; m_grp = '0;
    rst = 1'b1;
    drive(1, 1, 2'b00, 0, 0, 0, 0, 0, 16'h0);
    @(negedge clk);
    cycle(); cycle();
    rst = 1'b0;
    // R8 reset state
    chk("R8 reset valid", {63'd0, out_valid}, 64'd0);

    // R4 sign and zero extension
    drive(1, 1, 2'b00, 1, 1, 1, 1, 0, 16'h8001); cycle();
    drive(1, 1, 2'b01, 0, 0, 1, 1, 1, 16'h8001); cycle();
    // R3 register-2 and empty B
    drive(1, 1, 2'b10, 1, 1, 0, 0, 0, 16'hffff); cycle();
    drive(1, 1, 2'b00, 0, 0, 0, 0, 0, 16'h1234); cycle();
    // R5 reserved code
    drive(1, 1, 2'b11, 1, 1, 1, 1, 0, 16'h7fff); cycle();
    // R6 conflict on rotate, then stall and release carrying a conflict
    drive(1, 1, 2'b10, 1, 0, 1, 0, 0, 16'h0); cycle();
    drive(1, 0, 2'b01, 1, 1, 1, 0, 0, 16'h0); cycle();
    drive(1, 0, 2'b00, 1, 1, 1, 0, 0, 16'h0); cycle();
    drive(1, 1, 2'b01, 1, 1, 1, 0, 0, 16'h0); cycle();
    // R7 bubble drops valid
    drive(0, 1, 2'b00, 0, 0, 0, 0, 0, 16'h0); cycle();
    // R8 reset with a live transfer
    drive(1, 1, 2'b01, 1, 1, 1, 0, 0, 16'h0); rst = 1'b1; cycle(); rst = 1'b0;

    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 10) < 7, ($urandom % 4) != 0, 2'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            ($urandom % 3 == 0) ? (16'h8000 | 16'($urandom)) : 16'($urandom));
      cycle();
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule